// File: doc/BRIEF.md
# PCM Highway Time-Slot Port

This block connects one serial PCM highway to the internal sample side of a voice path. The highway carries an external bit clock and an 8 kHz frame-sync pulse. Every frame the port picks up to two receive time slots off the serial input. It hands each captured slot to the internal side as a one-cycle strobe, tagged with its channel. It also drives one transmit time slot onto the serial output and leaves the line released, with the output enable low, in every other bit period. An external pad cell built from `tx_data_o` and `tx_oe_o` produces the tri-state line.

The coding register chooses 16-bit linear samples or 8-bit companded bytes. Companded bytes are carried as they are, and the port does no companding arithmetic. The slot width follows the coding: 16 bits in linear mode, giving 16 slots in a 256-bit frame, and 8 bits in companded mode, giving 32 slots. The transmit path assumes a 2.048 MHz bit clock, which gives 256 bit periods per frame. The receive side also works with slower bit clocks, down to 64 kHz.

The bit clock and frame sync are sampled by the block clock `clk`, so every bit-clock level must last at least two `clk` cycles. The slot and coding settings and the transmit sample are taken over only at a frame start, so no frame ever mixes two settings.

Top module: `pcm_slot_port`

## Requirements
- R1: `cfg_coding_i` selects the coding. 0 and 3 mean 16-bit linear, with 16-bit slots numbered 0 to 15. 1 (mu-law) and 2 (A-law) mean 8-bit companded, with 8-bit slots numbered 0 to 31.
- R2: A rising bit-clock edge seen while `fsync_i` is high starts bit 0 of slot 0. The bit count then advances by one on each later rising edge. Both directions carry each slot MSB first.
- R3: `tx_data_o` and `tx_oe_o` change only after a rising bit-clock edge. `tx_oe_o` is high exactly during the bit periods of the transmit slot, and only while `cfg_tx_en_i` is set.
- R4: `rx_data_i` is sampled on the falling bit-clock edges. After the falling edge that captures the last bit of an enabled receive slot, `rx_valid_o` is high for exactly one `clk` cycle with the slot word on `rx_sample_o`.
- R5: The two receive channels each have their own slot number and enable. `rx_chan_o` is 0 or 1 for the channel that owns the slot. When both channels name the same slot, only channel 0 is reported.
- R6: A slot number at or above the slot count of the active coding disables that slot. A transmit slot so numbered is never driven, and a receive slot so numbered is never captured.
- R7: The transmit word is taken at each frame start from the last sample presented with `tx_sample_valid_i`. If no new sample has arrived, the previous word is sent again. A sample presented in the same `clk` cycle as the frame-start edge is used for that frame.
- R8: Changes on the coding, slot and enable inputs take effect only at the next frame start. A frame already in progress keeps the settings it started with.
- R9: In companded mode the received byte appears on `rx_sample_o[7:0]` with bits 15:8 zero. The transmitted byte is `tx_sample_i[7:0]`.
- R10: During and after reset, and until the first frame sync, `tx_oe_o` and `rx_valid_o` stay low.
- R11: If 256 or more bit periods pass without a frame sync, the port drives and captures nothing until the next frame sync.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock that samples the highway signals |
| rst | input | 1 | Synchronous reset, active high |
| bclk_i | input | 1 | Highway bit clock |
| fsync_i | input | 1 | Frame sync, one bit period wide |
| rx_data_i | input | 1 | Serial receive data |
| tx_data_o | output | 1 | Serial transmit data |
| tx_oe_o | output | 1 | Transmit output enable, low means the line is released |
| cfg_coding_i | input | 2 | Coding select (R1) |
| cfg_rx0_slot_i | input | 5 | Receive channel 0 slot number |
| cfg_rx0_en_i | input | 1 | Receive channel 0 enable |
| cfg_rx1_slot_i | input | 5 | Receive channel 1 slot number |
| cfg_rx1_en_i | input | 1 | Receive channel 1 enable |
| cfg_tx_slot_i | input | 5 | Transmit slot number |
| cfg_tx_en_i | input | 1 | Transmit enable |
| tx_sample_i | input | 16 | Sample to send |
| tx_sample_valid_i | input | 1 | Strobe for `tx_sample_i` |
| rx_sample_o | output | 16 | Received sample |
| rx_valid_o | output | 1 | Received-sample strobe |
| rx_chan_o | output | 1 | Receive channel index of the strobe |

## Verification
The frame-start latch and the arrival of a new transmit sample can happen in the same `clk` cycle. The bench provokes this by raising `tx_sample_valid_i` on the same cycle as the bit-clock rise that carries the frame sync. It then requires the new word, and not the stale one, to appear bit by bit in the transmit slot. The second overlap is two receive channels claiming one slot. In that case exactly one strobe, tagged channel 0, must come out.

// File: rtl/pcm_pkg.sv
package pcm_pkg;

    localparam int FRAME_BITS = 256;
    localparam int SAMPLE_W   = 16;
    localparam int NARROW_W   = 8;
    localparam int NUM_RX     = 2;
    localparam int SLOT_W     = $clog2(FRAME_BITS / NARROW_W);
    localparam int BIT_W      = $clog2(SAMPLE_W);
    localparam int NBIT_W     = $clog2(NARROW_W);
    localparam int CNT_W      = $clog2(FRAME_BITS) + 1;
    localparam int CH_W       = (NUM_RX > 1) ? $clog2(NUM_RX) : 1;

    typedef enum logic [1:0] {
        CODE_LINEAR  = 2'd0,
        CODE_MULAW   = 2'd1,
        CODE_ALAW    = 2'd2,
        CODE_LINEAR2 = 2'd3
    } coding_e;

    typedef struct packed {
        logic [1:0]                    coding;
        logic [NUM_RX-1:0][SLOT_W-1:0] rx_slot;
        logic [NUM_RX-1:0]             rx_en;
        logic [SLOT_W-1:0]             tx_slot;
        logic                          tx_en;
    } port_cfg_t;

    typedef struct packed {
        logic              in_frame;
        logic              narrow;
        logic [SLOT_W-1:0] slot;
        logic [BIT_W-1:0]  bit_idx;
        logic              last_bit;
    } slot_pos_t;

    function automatic logic is_narrow(input logic [1:0] coding);
        return (coding == CODE_MULAW) || (coding == CODE_ALAW);
    endfunction

    function automatic logic slot_in_range(input logic narrow, input logic [SLOT_W-1:0] s);
        if (narrow)
            return int'(s) < (FRAME_BITS / NARROW_W);
        return int'(s) < (FRAME_BITS / SAMPLE_W);
    endfunction

endpackage

// File: rtl/pcm_frame_timer.sv
module pcm_frame_timer
    import pcm_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      bclk_i,
    input  logic      fsync_i,
    input  port_cfg_t cfg_in,
    output logic      rise,
    output logic      fall,
    output logic      frame_start,
    output port_cfg_t cfg_act,
    output slot_pos_t pos
);

    logic             bclk_q;
    logic [CNT_W-1:0] cnt;

    localparam logic [CNT_W-1:0] CNT_END = CNT_W'(FRAME_BITS);

    assign rise        = bclk_i & ~bclk_q;
    assign fall        = ~bclk_i & bclk_q;
    assign frame_start = rise & fsync_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            bclk_q  <= 1'b0;
            cnt     <= CNT_END;
            cfg_act <= '0;
        end else begin
            bclk_q <= bclk_i;
            if (frame_start) begin
                cnt     <= '0;
                cfg_act <= cfg_in;
            end else if (rise && cnt != CNT_END) begin
                cnt <= cnt + CNT_W'(1);
            end
        end
    end

    always_comb begin
        pos.in_frame = (cnt < CNT_END);
        pos.narrow   = is_narrow(cfg_act.coding);
        if (pos.narrow) begin
            pos.slot     = SLOT_W'(cnt[CNT_W-2:NBIT_W]);
            pos.bit_idx  = BIT_W'(cnt[NBIT_W-1:0]);
            pos.last_bit = (cnt[NBIT_W-1:0] == {NBIT_W{1'b1}});
        end else begin
            pos.slot     = SLOT_W'(cnt[CNT_W-2:BIT_W]);
            pos.bit_idx  = cnt[BIT_W-1:0];
            pos.last_bit = (cnt[BIT_W-1:0] == {BIT_W{1'b1}});
        end
    end

    AST_CNT_RESTART: assert property (@(posedge clk) disable iff (rst)
        frame_start |=> (cnt == '0)); // R2
    AST_CNT_ON_RISE: assert property (@(posedge clk) disable iff (rst)
        !rise |=> $stable(cnt)); // R2
    AST_CFG_HOLD: assert property (@(posedge clk) disable iff (rst)
        !frame_start |=> $stable(cfg_act)); // R8

endmodule

// File: rtl/pcm_tx_path.sv
module pcm_tx_path
    import pcm_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                frame_start,
    input  slot_pos_t           pos,
    input  port_cfg_t           cfg,
    input  logic [SAMPLE_W-1:0] tx_sample_i,
    input  logic                tx_sample_valid_i,
    output logic                tx_data_o,
    output logic                tx_oe_o
);

    logic [SAMPLE_W-1:0] pend;
    logic [SAMPLE_W-1:0] word;
    logic [BIT_W-1:0]    idx;

    localparam logic [BIT_W-1:0] TOP_WIDE   = BIT_W'(SAMPLE_W - 1);
    localparam logic [BIT_W-1:0] TOP_NARROW = BIT_W'(NARROW_W - 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            pend <= '0;
            word <= '0;
        end else begin
            if (tx_sample_valid_i)
                pend <= tx_sample_i;
            if (frame_start)
                word <= tx_sample_valid_i ? tx_sample_i : pend;
        end
    end

    assign idx     = (pos.narrow ? TOP_NARROW : TOP_WIDE) - pos.bit_idx;
    assign tx_oe_o = cfg.tx_en && pos.in_frame &&
                     slot_in_range(pos.narrow, cfg.tx_slot) &&
                     (pos.slot == cfg.tx_slot);
    assign tx_data_o = tx_oe_o & word[idx];

    AST_TX_REPEAT: assert property (@(posedge clk) disable iff (rst)
        (frame_start && !tx_sample_valid_i) |=> (word == $past(pend))); // R7
    AST_TX_FRESH: assert property (@(posedge clk) disable iff (rst)
        (frame_start && tx_sample_valid_i) |=> (word == $past(tx_sample_i))); // R7
    AST_TX_QUIET_OUT_OF_FRAME: assert property (@(posedge clk) disable iff (rst)
        !pos.in_frame |-> !tx_oe_o); // R11

endmodule

// File: rtl/pcm_rx_path.sv
module pcm_rx_path
    import pcm_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                fall,
    input  slot_pos_t           pos,
    input  port_cfg_t           cfg,
    input  logic                rx_data_i,
    output logic [SAMPLE_W-1:0] rx_sample_o,
    output logic                rx_valid_o,
    output logic [CH_W-1:0]     rx_chan_o
);

    logic [NUM_RX-1:0]   hit;
    logic [CH_W-1:0]     sel;
    logic                found;
    logic [SAMPLE_W-1:0] shreg;

    for (genvar c = 0; c < NUM_RX; c++) begin : g_match
        assign hit[c] = cfg.rx_en[c] && pos.in_frame &&
                        slot_in_range(pos.narrow, cfg.rx_slot[c]) &&
                        (pos.slot == cfg.rx_slot[c]);
    end

    always_comb begin
        sel   = '0;
        found = |hit;
        for (int c = NUM_RX - 1; c >= 0; c--) begin
            if (hit[c])
                sel = CH_W'(c);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg       <= '0;
            rx_sample_o <= '0;
            rx_valid_o  <= 1'b0;
            rx_chan_o   <= '0;
        end else begin
            rx_valid_o <= 1'b0;
            if (fall && found) begin
                shreg <= {shreg[SAMPLE_W-2:0], rx_data_i};
                if (pos.last_bit) begin
                    rx_valid_o <= 1'b1;
                    rx_chan_o  <= sel;
                    if (pos.narrow)
                        rx_sample_o <= {{(SAMPLE_W-NARROW_W){1'b0}},
                                        shreg[NARROW_W-2:0], rx_data_i};
                    else
                        rx_sample_o <= {shreg[SAMPLE_W-2:0], rx_data_i};
                end
            end
        end
    end

    AST_RX_NARROW_ZERO_EXT: assert property (@(posedge clk) disable iff (rst)
        (rx_valid_o && pos.narrow) |-> (rx_sample_o[SAMPLE_W-1:NARROW_W] == '0)); // R9
    AST_RX_SINGLE_OWNER: assert property (@(posedge clk) disable iff (rst)
        (fall && found && pos.last_bit && hit[0]) |=> (rx_chan_o == '0)); // R5

endmodule

// File: rtl/pcm_slot_port.sv
module pcm_slot_port
    import pcm_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  bclk_i,
    input  logic                  fsync_i,
    input  logic                  rx_data_i,
    output logic                  tx_data_o,
    output logic                  tx_oe_o,
    input  logic [1:0]            cfg_coding_i,
    input  logic [SLOT_W-1:0]     cfg_rx0_slot_i,
    input  logic                  cfg_rx0_en_i,
    input  logic [SLOT_W-1:0]     cfg_rx1_slot_i,
    input  logic                  cfg_rx1_en_i,
    input  logic [SLOT_W-1:0]     cfg_tx_slot_i,
    input  logic                  cfg_tx_en_i,
    input  logic [SAMPLE_W-1:0]   tx_sample_i,
    input  logic                  tx_sample_valid_i,
    output logic [SAMPLE_W-1:0]   rx_sample_o,
    output logic                  rx_valid_o,
    output logic [CH_W-1:0]       rx_chan_o
);

    port_cfg_t cfg_in;
    port_cfg_t cfg_act;
    slot_pos_t pos;
    logic      rise;
    logic      fall;
    logic      frame_start;

    always_comb begin
        cfg_in            = '0;
        cfg_in.coding     = cfg_coding_i;
        cfg_in.rx_slot[0] = cfg_rx0_slot_i;
        cfg_in.rx_slot[1] = cfg_rx1_slot_i;
        cfg_in.rx_en[0]   = cfg_rx0_en_i;
        cfg_in.rx_en[1]   = cfg_rx1_en_i;
        cfg_in.tx_slot    = cfg_tx_slot_i;
        cfg_in.tx_en      = cfg_tx_en_i;
    end

    pcm_frame_timer u_timer (
        .clk         (clk),
        .rst         (rst),
        .bclk_i      (bclk_i),
        .fsync_i     (fsync_i),
        .cfg_in      (cfg_in),
        .rise        (rise),
        .fall        (fall),
        .frame_start (frame_start),
        .cfg_act     (cfg_act),
        .pos         (pos)
    );

    pcm_tx_path u_tx (
        .clk               (clk),
        .rst               (rst),
        .frame_start       (frame_start),
        .pos               (pos),
        .cfg               (cfg_act),
        .tx_sample_i       (tx_sample_i),
        .tx_sample_valid_i (tx_sample_valid_i),
        .tx_data_o         (tx_data_o),
        .tx_oe_o           (tx_oe_o)
    );

    pcm_rx_path u_rx (
        .clk         (clk),
        .rst         (rst),
        .fall        (fall),
        .pos         (pos),
        .cfg         (cfg_act),
        .rx_data_i   (rx_data_i),
        .rx_sample_o (rx_sample_o),
        .rx_valid_o  (rx_valid_o),
        .rx_chan_o   (rx_chan_o)
    );

    AST_TX_EDGE_ALIGNED: assert property (@(posedge clk) disable iff (rst)
        !$past(rise) |-> ($stable(tx_oe_o) && $stable(tx_data_o))); // R3
    AST_RX_AFTER_FALL: assert property (@(posedge clk) disable iff (rst)
        rx_valid_o |-> $past(fall)); // R4
    AST_RX_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        rx_valid_o |=> !rx_valid_o); // R4

endmodule

// File: tb/test_pcm_slot_port.sv
module test_pcm_slot_port;

    typedef struct packed {
        logic [1:0]  coding;
        logic [4:0]  r0s;
        logic        r0e;
        logic [4:0]  r1s;
        logic        r1e;
        logic [4:0]  ts;
        logic        te;
        logic [15:0] samp;
        logic [7:0]  seed;
    } vec_t;

    // coding, rx0 slot/en, rx1 slot/en, tx slot/en, sample, rx seed
    localparam vec_t VECS [6] = '{
        '{2'd0, 5'd3,  1'b1, 5'd10, 1'b1, 5'd5,  1'b1, 16'hA5C3, 8'd1},  // R1 R4 R5 linear
        '{2'd1, 5'd0,  1'b1, 5'd31, 1'b1, 5'd31, 1'b1, 16'h12F0, 8'd2},  // R2 R9 edges
        '{2'd2, 5'd7,  1'b1, 5'd7,  1'b1, 5'd0,  1'b1, 16'h775A, 8'd3},  // R5 shared slot
        '{2'd0, 5'd16, 1'b1, 5'd15, 1'b1, 5'd20, 1'b1, 16'hBEEF, 8'd4},  // R6 out of range
        '{2'd3, 5'd0,  1'b1, 5'd1,  1'b0, 5'd15, 1'b1, 16'h8001, 8'd5},  // R1 code 3
        '{2'd1, 5'd20, 1'b1, 5'd2,  1'b1, 5'd2,  1'b0, 16'h0F3C, 8'd6}   // R3 tx off
    };

    localparam int MAXB = 272;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bclk = 1'b0;
    logic        fsync = 1'b0;
    logic        rx_data = 1'b0;
    logic [1:0]  cfg_coding = '0;
    logic [4:0]  cfg_r0s = '0, cfg_r1s = '0, cfg_ts = '0;
    logic        cfg_r0e = 1'b0, cfg_r1e = 1'b0, cfg_te = 1'b0;
    logic [15:0] tx_samp = '0;
    logic        tx_val = 1'b0;
    wire         tx_data_o, tx_oe_o, rx_valid_o;
    wire  [15:0] rx_sample_o;
    wire  [0:0]  rx_chan_o;

    // expected configuration of the frame under test
    logic [1:0]  e_coding;
    logic [4:0]  e_r0s, e_r1s, e_ts;
    logic        e_r0e, e_r1e, e_te;
    logic [15:0] e_samp;

    logic        rec_oe [MAXB];
    logic        rec_d  [MAXB];
    logic [15:0] cap_d  [8];
    logic        cap_c  [8];
    int          cap_n = 0;
    int          n_chk = 0;
    int          n_err = 0;
    bit          done  = 0;

    always #5 clk = ~clk;

    pcm_slot_port i_pcm_slot_port (
        .clk (clk), .rst (rst), .bclk_i (bclk), .fsync_i (fsync), .rx_data_i (rx_data),
        .tx_data_o (tx_data_o), .tx_oe_o (tx_oe_o), .cfg_coding_i (cfg_coding),
        .cfg_rx0_slot_i (cfg_r0s), .cfg_rx0_en_i (cfg_r0e),
        .cfg_rx1_slot_i (cfg_r1s), .cfg_rx1_en_i (cfg_r1e),
        .cfg_tx_slot_i (cfg_ts), .cfg_tx_en_i (cfg_te),
        .tx_sample_i (tx_samp), .tx_sample_valid_i (tx_val),
        .rx_sample_o (rx_sample_o), .rx_valid_o (rx_valid_o), .rx_chan_o (rx_chan_o)
    );

    always @(negedge clk) begin
        if (rx_valid_o && cap_n < 8) begin
            cap_d[cap_n] = rx_sample_o;
            cap_c[cap_n] = rx_chan_o[0];
            cap_n++;
        end
    end

    function automatic logic rxb(input int seed, input int i);
        int v;
        v = (i * 5 + seed * 3) ^ (i >> 2);
        return v[1];
    endfunction

    task automatic set_cfg(input vec_t v);
        @(negedge clk);
        cfg_coding = v.coding; cfg_r0s = v.r0s; cfg_r0e = v.r0e;
        cfg_r1s = v.r1s; cfg_r1e = v.r1e; cfg_ts = v.ts; cfg_te = v.te;
        e_coding = v.coding; e_r0s = v.r0s; e_r0e = v.r0e;
        e_r1s = v.r1s; e_r1e = v.r1e; e_ts = v.ts; e_te = v.te;
    endtask

    task automatic load_sample(input logic [15:0] s);
        @(negedge clk);
        tx_samp = s; tx_val = 1'b1;
        @(negedge clk);
        tx_val = 1'b0;
        e_samp = s;
    endtask

    task automatic drive_bit(input int i, input bit fs, input bit vfs,
                             input logic [15:0] vs, input logic rxv);
        @(negedge clk);
        bclk = 1'b1; fsync = fs; rx_data = rxv;
        if (vfs) begin tx_samp = vs; tx_val = 1'b1; end
        @(negedge clk);
        tx_val = 1'b0;
        repeat (3) @(negedge clk);
        if (i < MAXB) begin rec_oe[i] = tx_oe_o; rec_d[i] = tx_data_o; end
        bclk = 1'b0; fsync = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    // chg_bit >= 0: the cfg inputs switch to nx at that bit, mid-frame
    task automatic run_frame(input int nbits, input bit with_fs, input bit vfs,
                             input logic [15:0] vs, input int seed,
                             input int chg_bit, input vec_t nx);
        cap_n = 0;
        for (int i = 0; i < nbits; i++) begin
            if (i == chg_bit) begin
                cfg_coding = nx.coding; cfg_r0s = nx.r0s; cfg_r0e = nx.r0e;
                cfg_r1s = nx.r1s; cfg_r1e = nx.r1e; cfg_ts = nx.ts; cfg_te = nx.te;
            end
            drive_bit(i, with_fs && i == 0, vfs && i == 0, vs, rxb(seed, i));
        end
    endtask

    task automatic check_frame(input int nbits, input int seed, input string req);
        bit          narrow;
        int          w, ns, bad_i, exp_n;
        logic        eo, ed;
        logic [15:0] ev [4];
        logic        ec [4];
        bit          rx_bad;
        narrow = (e_coding == 2'd1) || (e_coding == 2'd2);
        w  = narrow ? 8 : 16;
        ns = 256 / w;
        bad_i = -1;
        for (int i = 0; i < nbits; i++) begin
            eo = e_te && (i < 256) && ((i / w) == int'(e_ts)) && (int'(e_ts) < ns);
            ed = eo ? e_samp[w - 1 - (i % w)] : 1'b0;
            if (bad_i < 0 && (rec_oe[i] !== eo || (eo && rec_d[i] !== ed))) bad_i = i;
        end
        n_chk++;
        if (bad_i >= 0) begin
            n_err++;
            eo = e_te && (bad_i < 256) && ((bad_i / w) == int'(e_ts)) && (int'(e_ts) < ns);
            ed = eo ? e_samp[w - 1 - (bad_i % w)] : 1'b0;
            $display("FAIL %s tx bit %0d: oe/data %b%b expected %b%b", req, bad_i,
                     rec_oe[bad_i], rec_d[bad_i], eo, ed);
        end
        exp_n = 0;
        for (int s = 0; s < ns; s++) begin
            logic h0, h1;
            logic [15:0] v;
            h0 = e_r0e && (int'(e_r0s) == s);
            h1 = e_r1e && (int'(e_r1s) == s);
            if (h0 || h1) begin
                v = '0;
                for (int b = 0; b < w; b++) v = {v[14:0], rxb(seed, s * w + b)};
                ev[exp_n] = v;
                ec[exp_n] = h0 ? 1'b0 : 1'b1;
                exp_n++;
            end
        end
        rx_bad = (cap_n != exp_n);
        for (int k = 0; k < exp_n && k < cap_n; k++)
            if (cap_d[k] !== ev[k] || cap_c[k] !== ec[k]) rx_bad = 1;
        n_chk++;
        if (rx_bad) begin
            n_err++;
            $display("FAIL %s rx: %0d strobes first %h/%0d, expected %0d first %h/%0d", req,
                     cap_n, cap_d[0], cap_c[0], exp_n, ev[0], ec[0]);
        end
    endtask

    initial begin
        vec_t nx;
        nx = '0;
        repeat (4) @(negedge clk);
        n_chk++;
        if (tx_oe_o !== 1'b0 || rx_valid_o !== 1'b0) begin
            n_err++;
            $display("FAIL R10 in reset: oe %b valid %b expected 0 0", tx_oe_o, rx_valid_o);
        end
        rst = 1'b0;
        // R10: enabled slot 0 but no frame sync yet
        set_cfg('{2'd0, 5'd0, 1'b1, 5'd1, 1'b1, 5'd0, 1'b1, 16'hFFFF, 8'd0});
        load_sample(16'hFFFF);
        run_frame(40, 1'b0, 1'b0, 16'h0, 7, -1, nx);
        begin
            int oes;
            oes = 0;
            for (int i = 0; i < 40; i++) oes += int'(rec_oe[i]);
            n_chk++;
            if (oes != 0 || cap_n != 0) begin
                n_err++;
                $display("FAIL R10 before sync: oe bits %0d strobes %0d expected 0 0", oes, cap_n);
            end
        end

        for (int k = 0; k < 6; k++) begin
            set_cfg(VECS[k]);
            load_sample(VECS[k].samp);
            run_frame(256, 1'b1, 1'b0, 16'h0, int'(VECS[k].seed), -1, nx);
            case (k)
                0: check_frame(256, int'(VECS[k].seed), "R1 R3 R4 R5");
                1: check_frame(256, int'(VECS[k].seed), "R2 R9");
                2: check_frame(256, int'(VECS[k].seed), "R5 R9");
                3: check_frame(256, int'(VECS[k].seed), "R6");
                4: check_frame(256, int'(VECS[k].seed), "R1");
                default: check_frame(256, int'(VECS[k].seed), "R3 R6");
            endcase
        end

        // R7: repeat and same-cycle sample
        set_cfg('{2'd0, 5'd1, 1'b1, 5'd0, 1'b0, 5'd2, 1'b1, 16'h0, 8'd0});
        load_sample(16'h3C96);
        run_frame(256, 1'b1, 1'b0, 16'h0, 8, -1, nx);
        check_frame(256, 8, "R7");
        run_frame(256, 1'b1, 1'b0, 16'h0, 9, -1, nx);
        check_frame(256, 9, "R7 repeat");
        e_samp = 16'hE1D2;
        run_frame(256, 1'b1, 1'b1, 16'hE1D2, 10, -1, nx);
        check_frame(256, 10, "R7 same cycle");

        // R8: mid-frame change waits for next sync
        set_cfg('{2'd1, 5'd9, 1'b1, 5'd0, 1'b0, 5'd4, 1'b1, 16'h0, 8'd0});
        load_sample(16'h00C7);
        nx = '{2'd0, 5'd1, 1'b1, 5'd3, 1'b1, 5'd9, 1'b1, 16'h0, 8'd0};
        run_frame(256, 1'b1, 1'b0, 16'h0, 11, 100, nx);
        check_frame(256, 11, "R8 old");
        e_coding = nx.coding; e_r0s = nx.r0s; e_r0e = nx.r0e;
        e_r1s = nx.r1s; e_r1e = nx.r1e; e_ts = nx.ts; e_te = nx.te;
        nx = '0;
        run_frame(256, 1'b1, 1'b0, 16'h0, 12, -1, nx);
        check_frame(256, 12, "R8 new");

        // R11: frame longer than 256 bit periods
        set_cfg('{2'd0, 5'd15, 1'b1, 5'd0, 1'b1, 5'd15, 1'b1, 16'h0, 8'd0});
        load_sample(16'h6D2B);
        run_frame(272, 1'b1, 1'b0, 16'h0, 13, -1, nx);
        check_frame(272, 13, "R11");

        done = 1;
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end

endmodule